// File: doc/BRIEF.md
# Capture Command Sequencer for a Serial-Linked Logic Analyzer

This block runs in the fixed-frequency clock domain and links a byte-wide serial receiver and transmitter to a triggered capture unit that runs on a separate, variable clock. A host sends a single arm command byte. The sequencer then raises the capture enable and waits for the capture unit to report that its 128-bit word is ready. It then streams that word back to the host one byte at a time through the transmitter. Last, it drives a clear so the capture unit returns to its starting state and can be armed again.

The capture-done flag crosses clock domains, so it passes through a synchronizer chain before the state machine uses it. The captured word is latched once, on the synchronized done, so later changes on the data bus cannot corrupt a stream already in progress. The transmitter handshake is conservative: a byte is offered only when the transmitter is not busy, and the next byte waits for a done report.

Top module: `ucc_capture_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cap_en`, `cap_clear` and `tx_valid` are all low.
- R2: When idle, a receive strobe carrying byte value 0x01 raises `cap_en` in the cycle after the strobe is sampled.
- R3: When idle, a strobe carrying any byte value other than 0x01, or value 0x01 with the strobe low, leaves `cap_en` low.
- R4: No byte is offered before the capture-done input has passed a two-stage synchronizer. The first `tx_valid` appears on the fourth clock edge after `cap_done` rises, provided the transmitter is not active.
- R5: Exactly 16 bytes are sent per capture, least significant byte first: byte k carries bits [8k+7:8k] of the captured word.
- R6: `tx_valid` is a single-cycle pulse that is only raised while `tx_active` is low. After each byte, the next one is offered only after `tx_done` has been seen and `tx_active` is low.
- R7: After the done report for the 16th byte, `cap_clear` rises with `cap_en` still high. Both stay high for as long as the synchronized capture-done stays high.
- R8: Two clock edges after `cap_done` falls, `cap_en` and `cap_clear` are still high. On the third edge both fall together and the block is idle again.
- R9: Receive strobes that arrive while a capture transaction is in progress are ignored. The stream is neither restarted nor lengthened.
- R10: The word is sampled when the synchronized done is first seen. Changes on `cap_data` after that point do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_byte | input | 8 | Received command byte |
| tx_valid | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_active | input | 1 | Transmitter busy |
| tx_done | input | 1 | Transmitter finished a byte |
| cap_en | output | 1 | Arm / enable for the capture unit |
| cap_clear | output | 1 | Return-to-initial-state request for the capture unit |
| cap_done | input | 1 | Capture complete (asynchronous to `clk`) |
| cap_data | input | 128 | Captured word |

## Verification
Each result has a fixed latency. `cap_en` follows an accepted command by one edge. The first `tx_valid` follows a rise of `cap_done` by exactly four edges: two synchronizer stages, the state change, and the output register. Release after a fall of `cap_done` takes three edges. The bench drives inputs on the falling clock edge and samples outputs on the next falling edge after the counted number of rising edges, and it checks both the cycle before each due point (still low) and the due point itself. Byte waits that depend on the bench's own transmitter model are polled with a bound, and each byte is compared against a slice computed from the stimulus word.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ARM       = 3'd1,
    ST_WAIT_DONE = 3'd2,
    ST_SEND      = 3'd3,
    ST_WAIT_TX   = 3'd4,
    ST_CLEAR     = 3'd5
  } ucc_state_e;

  // True when a received byte equals the arm command code.
  function automatic logic is_arm_cmd(input logic [7:0] b, input logic [7:0] code);
    return b == code;
  endfunction

  // Transmitter can accept a new byte.
  function automatic logic tx_ready(input logic active);
    return !active;
  endfunction

endpackage

// File: rtl/ucc_done_sync.sv
module ucc_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ucc_cmd_decode.sv
module ucc_cmd_decode #(
  parameter logic [7:0] CMD_ARM = 8'h01
) (
  input  logic       listen,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       arm_req
);
  import ucc_pkg::*;
  assign arm_req = listen && rx_valid && is_arm_cmd(rx_byte, CMD_ARM);
endmodule

// File: rtl/ucc_byte_serializer.sv
module ucc_byte_serializer #(
  parameter int DATA_W = 128,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] word,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              last
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= word;
      idx_q  <= '0;
    end else if (step) begin
      word_q <= word_q >> BYTE_W;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign cur_byte = word_q[BYTE_W-1:0];
  assign last     = (idx_q == IDX_W'(NBYTES - 1));
endmodule

// File: rtl/ucc_capture_ctrl.sv
module ucc_capture_ctrl #(
  parameter int         DATA_W      = 128,
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CMD_ARM     = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_active,
  input  logic              tx_done,
  output logic              cap_en,
  output logic              cap_clear,
  input  logic              cap_done,
  input  logic [DATA_W-1:0] cap_data
);
  import ucc_pkg::*;

  ucc_state_e        state_q, state_n;
  logic              arm_req;
  logic              done_sync;
  logic              byte_last;
  logic              load_word;
  logic              step_word;
  logic              offer_byte;
  logic [BYTE_W-1:0] cur_byte;
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_byte_q;

  ucc_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cap_done),
    .sync_out (done_sync)
  );

  ucc_cmd_decode #(.CMD_ARM(CMD_ARM)) u_dec (
    .listen   (state_q == ST_IDLE),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .arm_req  (arm_req)
  );

  ucc_byte_serializer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_word),
    .step     (step_word),
    .word     (cap_data),
    .cur_byte (cur_byte),
    .last     (byte_last)
  );

  always_comb begin
    state_n    = state_q;
    load_word  = 1'b0;
    step_word  = 1'b0;
    offer_byte = 1'b0;
    case (state_q)
      ST_IDLE:      if (arm_req) state_n = ST_ARM;
      ST_ARM:       state_n = ST_WAIT_DONE;
      ST_WAIT_DONE: if (done_sync) begin
                      load_word = 1'b1;
                      state_n   = ST_SEND;
                    end
      ST_SEND:      if (tx_ready(tx_active)) begin
                      offer_byte = 1'b1;
                      state_n    = ST_WAIT_TX;
                    end
      ST_WAIT_TX:   if (tx_done) begin
                      if (byte_last) state_n = ST_CLEAR;
                      else begin
                        step_word = 1'b1;
                        state_n   = ST_SEND;
                      end
                    end
      ST_CLEAR:     if (!done_sync) state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      state_q    <= state_n;
      tx_valid_q <= offer_byte;
      if (offer_byte) tx_byte_q <= cur_byte;
    end
  end

  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign cap_en    = (state_q != ST_IDLE);
  assign cap_clear = (state_q == ST_CLEAR);
endmodule

// File: rtl/ucc_capture_ctrl_chk.sv
module ucc_capture_ctrl_chk #(
  parameter int         DATA_W = 128,
  parameter int         BYTE_W = 8,
  parameter logic [7:0] CMD_ARM = 8'h01
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_valid,
  input logic       tx_active,
  input logic       cap_en,
  input logic       cap_clear,
  input logic       done_sync
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [CNT_W-1:0] sent_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sent_cnt <= '0;
    else if (!cap_en)  sent_cnt <= '0;
    else if (tx_valid) sent_cnt <= sent_cnt + 1'b1;
  end

  // R2
  arm_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && rx_valid && rx_byte == CMD_ARM) |=> cap_en);
  // R3
  arm_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !(rx_valid && rx_byte == CMD_ARM)) |=> !cap_en);
  // R6
  tx_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(!tx_active));
  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  // R5
  byte_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (sent_cnt < CNT_W'(NBYTES)));
  // R5
  full_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_clear) |-> (sent_cnt == CNT_W'(NBYTES)));
  // R7
  clear_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_clear |-> cap_en);
  // R7
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_clear && done_sync) |=> cap_clear);
  // R8
  joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_en) |-> $fell(cap_clear));
endmodule

bind ucc_capture_ctrl ucc_capture_ctrl_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CMD_ARM(CMD_ARM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .tx_valid  (tx_valid),
  .tx_active (tx_active),
  .cap_en    (cap_en),
  .cap_clear (cap_clear),
  .done_sync (done_sync)
);

// File: tb/tb_ucc_capture_ctrl.sv
`timescale 1ns/1ps
module tb_ucc_capture_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_byte = '0;
  logic         tx_valid;
  logic [7:0]   tx_byte;
  logic         tx_active = 1'b0;
  logic         tx_done = 1'b0;
  logic         cap_en;
  logic         cap_clear;
  logic         cap_done = 1'b0;
  logic [127:0] cap_data = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ucc_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_active(tx_active),
    .tx_done(tx_done), .cap_en(cap_en), .cap_clear(cap_clear),
    .cap_done(cap_done), .cap_data(cap_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // mode 0: done with active low; mode 1: done while still active
  task automatic run_txn(input logic [127:0] w, input int mode, input bit poke);
    int t;
    send_rx(8'h01);
    chk(cap_en == 1'b1, "R2 arm", cap_en, 1);
    repeat (3) begin
      @(negedge clk);
      chk(!tx_valid && !cap_clear, "R4 no tx before done", tx_valid, 0);
    end
    cap_data = w;
    cap_done = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(!tx_valid, "R4 sync latency early", tx_valid, 0);
    end
    @(negedge clk);
    chk(tx_valid, "R4 first byte on edge 4", tx_valid, 1);
    cap_data = ~w;  // R10: changes after sampling must not show
    for (int k = 0; k < 16; k++) begin
      t = 0;
      while (!tx_valid && t < 20) begin
        @(negedge clk);
        t++;
      end
      chk(tx_valid, "R6 byte offered", tx_valid, 1);
      chk(tx_byte == w[8*k +: 8], "R5 R10 byte order/value", tx_byte, w[8*k +: 8]);
      tx_active = 1'b1;
      if (poke && k == 0) begin
        rx_valid = 1'b1;  // R9
        rx_byte  = 8'h01;
      end
      @(negedge clk);
      rx_valid = 1'b0;
      chk(!tx_valid, "R6 single-cycle pulse", tx_valid, 0);
      repeat (2) begin
        @(negedge clk);
        chk(!tx_valid, "R6 hold while busy", tx_valid, 0);
      end
      if (mode == 0) begin
        tx_active = 1'b0;
        tx_done   = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
      end else begin
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        repeat (3) begin
          chk(!tx_valid, "R6 wait for active low", tx_valid, 0);
          @(negedge clk);
        end
        chk(!tx_valid, "R6 wait for active low", tx_valid, 0);
        tx_active = 1'b0;
      end
    end
    t = 0;
    while (!cap_clear && t < 10) begin
      chk(!tx_valid, "R9 no extra byte", tx_valid, 0);
      @(negedge clk);
      t++;
    end
    chk(cap_clear && cap_en, "R7 clear raised with enable", {cap_en, cap_clear}, 2'b11);
    repeat (6) begin
      @(negedge clk);
      chk(cap_clear && cap_en && !tx_valid, "R7 clear held",
          {tx_valid, cap_en, cap_clear}, 3'b011);
    end
    cap_done = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(cap_clear && cap_en, "R8 still held", {cap_en, cap_clear}, 2'b11);
    end
    @(negedge clk);
    chk(!cap_clear && !cap_en, "R8 joint release", {cap_en, cap_clear}, 2'b00);
  endtask

  initial begin
    logic [127:0] w;
    #1;
    chk(!cap_en && !cap_clear && !tx_valid, "R1 in reset",
        {cap_en, cap_clear, tx_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cap_en && !cap_clear && !tx_valid, "R1 after reset",
        {cap_en, cap_clear, tx_valid}, 0);

    // R3 sweep of every non-arm byte value while idle
    for (int b = 0; b < 256; b++) begin
      if (b == 1) continue;
      send_rx(8'(b));
      chk(!cap_en, "R3 ignored byte", cap_en, 0);
    end
    @(negedge clk);
    rx_byte = 8'h01;
    @(negedge clk);
    chk(!cap_en, "R3 code without strobe", cap_en, 0);

    for (int k = 0; k < 16; k++) w[8*k +: 8] = 8'(k * 17 + 3);
    run_txn(w, 0, 1'b0);
    run_txn({128{1'b1}}, 1, 1'b1);
    run_txn({32{4'h5}}, 0, 1'b1);
    w = '0;
    for (int k = 0; k < 16; k++) w[8*k + (k % 8)] = 1'b1;
    run_txn(w, 1, 1'b0);
    run_txn('0, 0, 1'b0);

    // R3 after returning idle
    send_rx(8'h02);
    chk(!cap_en, "R3 idle again", cap_en, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule